// File: doc/BRIEF.md
# Two-Client Burst Memory Arbiter

This block lets two client modules share one burst-oriented memory controller. Each client has three buffered ports, all using valid/ready handshakes. The command port takes a read/write flag and an address. The write port takes words going to memory. The read port returns words coming back from memory. Every port has its own FIFO. A client can therefore queue several commands, or a stock of write data, before any of it is serviced. The FIFOs also absorb the gap between the memory side, which moves one word per cycle, and slower clients.

The arbiter keeps at most one command outstanding at the controller. A command is eligible only when its client's data FIFO can carry a whole burst:
- A write needs the full burst of words already queued.
- A read needs room for every word that will come back.

When both clients are eligible, priority alternates: after each grant, the other client comes first. A parameter can select a fixed-priority variant instead, in which client 0 always wins ties. After a command is accepted, the arbiter stays with that client until the burst's last beat. During that time it presents the write FIFO head with an output enable and pops one word per controller take strobe, or it pushes one word into the read FIFO per controller data-valid strobe.

Top module: `mem_req_arbiter`

## Requirements
- R1: At most one command is outstanding. From acceptance (`mc_req_valid` and `mc_req_ready` high together) until the last of BURST beats, `mc_req_valid` stays low, and at most one client is granted.
- R2: Once raised, `mc_req_valid` stays high with `mc_write` and `mc_addr` unchanged until the cycle in which `mc_req_ready` is high.
- R3: In round-robin mode (FIXED_PRIO=0), when both clients are eligible at a decision, the client not granted last wins. After reset, client 0 wins the first tie.
- R4: A write command (`mc_write`=1) is not issued while its client's write FIFO holds fewer than BURST words.
- R5: A read command (`mc_write`=0) is not issued while its client's read FIFO has fewer than BURST free entries.
- R6: A client whose head command is blocked by R4 or R5 does not hold back an eligible command from the other client.
- R7: Throughout a write burst, `mc_wdata_oe` is high. `mc_wdata` shows the granted client's write words in arrival order and advances by one word per cycle in which `mc_wr_take` is high. `mc_wdata_oe` is low once the BURST-th take is done.
- R8: During a read burst, each cycle with `mc_rd_valid` high stores `mc_rd_data` into the granted client's read FIFO. The client receives these words in order on its read port.
- R9: `mc_wr_take` and `mc_rd_valid` are ignored when no burst of the matching direction is in progress. No write word is consumed and no read word is stored.
- R10: After reset, no command is issued, `mc_wdata_oe` is low, all FIFOs are empty (`cli_rd_valid`=0, `cli_req_ready` and `cli_wr_ready` all 1), and the round-robin pointer favours client 0.
- R11: A client's command port drops `cli_req_ready` when its command FIFO holds REQ_DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cli_req_valid | input | 2 | Command valid, one bit per client |
| cli_req_ready | output | 2 | Command FIFO has room |
| cli_req_write | input | 2 | 1 = write command, 0 = read command |
| cli_req_addr | input | 2*AW | Command address; client c in bits [c*AW +: AW] |
| cli_wr_valid | input | 2 | Write word valid |
| cli_wr_ready | output | 2 | Write FIFO has room |
| cli_wr_data | input | 2*DW | Write words; client c in bits [c*DW +: DW] |
| cli_rd_valid | output | 2 | Read FIFO holds a word |
| cli_rd_ready | input | 2 | Client takes the read word |
| cli_rd_data | output | 2*DW | Read FIFO head; client c in bits [c*DW +: DW] |
| mc_req_valid | output | 1 | Command offered to the controller |
| mc_req_ready | input | 1 | Controller accepts the command |
| mc_write | output | 1 | Direction of the offered command |
| mc_addr | output | AW | Address of the offered command |
| mc_wdata | output | DW | Write word for the controller |
| mc_wdata_oe | output | 1 | Write data drive enable during a write burst |
| mc_wr_take | input | 1 | Controller consumes one write word |
| mc_rd_valid | input | 1 | Controller delivers one read word |
| mc_rd_data | input | DW | Read word from the controller |

## Verification
Two things can coincide in one cycle: the grant decision and a change in data-FIFO occupancy. The bench makes them coincide by keeping the arbiter waiting on an unacknowledged command while it fills the other client's write FIFO and queues a second command. At the next decision, both clients become eligible at once, and the bench judges the winner from the last-served client alone. The bench also blocks one client by FIFO occupancy while the other is ready, and checks that every transfer beat leaves `mc_req_valid` low even though a competing command is waiting.

// File: rtl/arb_pkg.sv
package arb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CMD  = 2'd1,
      ST_XFER = 2'd2
   } arb_state_e;

   localparam int unsigned ARB_CLIENTS = 2;

endpackage

// File: rtl/arb_fifo.sv
module arb_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic [CW-1:0]    count,
   output logic [CW-1:0]    space
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("arb_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic             do_push, do_pop;

   assign do_push = push && (space != '0);
   assign do_pop  = pop && (count != '0);
   assign head    = mem[rptr];
   assign space   = CW'(DEPTH) - count;

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         if (do_pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter bit FIXED_PRIO = 1'b0
) (
   input  logic [1:0] elig,
   input  logic       ptr,
   output logic [1:0] win
);

   logic first;

   if (FIXED_PRIO) begin : g_fixed
      assign first = 1'b0;
   end else begin : g_rr
      assign first = ptr;
   end

   always_comb begin
      win = 2'b00;
      if (first == 1'b0) begin
         if (elig[0])      win = 2'b01;
         else if (elig[1]) win = 2'b10;
      end else begin
         if (elig[1])      win = 2'b10;
         else if (elig[0]) win = 2'b01;
      end
   end

endmodule

// File: rtl/arb_burst_seq.sv
module arb_burst_seq
   import arb_pkg::*;
#(
   parameter int unsigned AW    = 24,
   parameter int unsigned BURST = 8,
   localparam int unsigned BCW  = $clog2(BURST + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [1:0]    win,
   input  logic          win_write,
   input  logic [AW-1:0] win_addr,
   input  logic          mc_req_ready,
   input  logic          mc_wr_take,
   input  logic          mc_rd_valid,
   output logic [1:0]    gnt,
   output logic          launch,
   output logic          ptr,
   output logic          mc_req_valid,
   output logic          mc_write,
   output logic [AW-1:0] mc_addr,
   output logic          mc_wdata_oe,
   output logic          wr_beat,
   output logic          rd_beat
);

   if (BURST < 1) begin : g_bad_burst
      $error("arb_burst_seq: BURST must be at least 1");
   end

   arb_state_e     state;
   logic [BCW-1:0] beats;
   logic           last_beat;

   assign launch       = (state == ST_IDLE) && (win != 2'b00);
   assign mc_req_valid = (state == ST_CMD);
   assign mc_wdata_oe  = (state == ST_XFER) && mc_write;
   assign wr_beat      = (state == ST_XFER) && mc_write && mc_wr_take;
   assign rd_beat      = (state == ST_XFER) && !mc_write && mc_rd_valid;
   assign last_beat    = (wr_beat || rd_beat) && (beats == BCW'(BURST - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         gnt      <= 2'b00;
         ptr      <= 1'b0;
         beats    <= '0;
         mc_write <= 1'b0;
         mc_addr  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (launch) begin
                  state    <= ST_CMD;
                  gnt      <= win;
                  ptr      <= win[0];
                  mc_write <= win_write;
                  mc_addr  <= win_addr;
               end
            end
            ST_CMD: begin
               if (mc_req_ready) begin
                  state <= ST_XFER;
                  beats <= '0;
               end
            end
            ST_XFER: begin
               if (last_beat) begin
                  state <= ST_IDLE;
                  gnt   <= 2'b00;
               end else if (wr_beat || rd_beat) begin
                  beats <= beats + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
   import arb_pkg::*;
#(
   parameter int unsigned AW         = 24,
   parameter int unsigned DW         = 32,
   parameter int unsigned BURST      = 8,
   parameter int unsigned REQ_DEPTH  = 4,
   parameter int unsigned DATA_DEPTH = 16,
   parameter bit          FIXED_PRIO = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [1:0]      cli_req_valid,
   output logic [1:0]      cli_req_ready,
   input  logic [1:0]      cli_req_write,
   input  logic [2*AW-1:0] cli_req_addr,
   input  logic [1:0]      cli_wr_valid,
   output logic [1:0]      cli_wr_ready,
   input  logic [2*DW-1:0] cli_wr_data,
   output logic [1:0]      cli_rd_valid,
   input  logic [1:0]      cli_rd_ready,
   output logic [2*DW-1:0] cli_rd_data,
   output logic            mc_req_valid,
   input  logic            mc_req_ready,
   output logic            mc_write,
   output logic [AW-1:0]   mc_addr,
   output logic [DW-1:0]   mc_wdata,
   output logic            mc_wdata_oe,
   input  logic            mc_wr_take,
   input  logic            mc_rd_valid,
   input  logic [DW-1:0]   mc_rd_data
);

   localparam int unsigned NC  = ARB_CLIENTS;
   localparam int unsigned DCW = $clog2(DATA_DEPTH + 1);
   localparam int unsigned RCW = $clog2(REQ_DEPTH + 1);
   localparam logic [DCW-1:0] BURST_C = DCW'(BURST);

   if (DATA_DEPTH < BURST) begin : g_bad_data_depth
      $error("mem_req_arbiter: DATA_DEPTH must hold a whole burst");
   end
   if (REQ_DEPTH < 2) begin : g_bad_req_depth
      $error("mem_req_arbiter: REQ_DEPTH must be at least 2");
   end

   logic [NC-1:0]      gnt, win, elig, head_write;
   logic [NC*AW-1:0]   head_addr;
   logic [NC*DW-1:0]   wr_head;
   logic [NC*DCW-1:0]  wr_cnt_flat, rd_space_flat;
   logic               launch, ptr, wr_beat, rd_beat;

   for (genvar c = 0; c < NC; c++) begin : g_cli
      logic [AW:0]    req_head;
      logic [RCW-1:0] req_cnt, req_space;
      logic [DCW-1:0] wr_cnt, wr_space, rd_cnt, rd_space;

      arb_fifo #(.WIDTH(AW + 1), .DEPTH(REQ_DEPTH)) u_req (
         .clk       (clk),
         .rst       (rst),
         .push      (cli_req_valid[c]),
         .push_data ({cli_req_write[c], cli_req_addr[c*AW +: AW]}),
         .pop       (launch && win[c]),
         .head      (req_head),
         .count     (req_cnt),
         .space     (req_space)
      );

      arb_fifo #(.WIDTH(DW), .DEPTH(DATA_DEPTH)) u_wr (
         .clk       (clk),
         .rst       (rst),
         .push      (cli_wr_valid[c]),
         .push_data (cli_wr_data[c*DW +: DW]),
         .pop       (wr_beat && gnt[c]),
         .head      (wr_head[c*DW +: DW]),
         .count     (wr_cnt),
         .space     (wr_space)
      );

      arb_fifo #(.WIDTH(DW), .DEPTH(DATA_DEPTH)) u_rd (
         .clk       (clk),
         .rst       (rst),
         .push      (rd_beat && gnt[c]),
         .push_data (mc_rd_data),
         .pop       (cli_rd_ready[c]),
         .head      (cli_rd_data[c*DW +: DW]),
         .count     (rd_cnt),
         .space     (rd_space)
      );

      assign cli_req_ready[c] = (req_space != '0);
      assign cli_wr_ready[c]  = (wr_space != '0);
      assign cli_rd_valid[c]  = (rd_cnt != '0);

      assign head_write[c]             = req_head[AW];
      assign head_addr[c*AW +: AW]     = req_head[AW-1:0];
      assign wr_cnt_flat[c*DCW +: DCW]   = wr_cnt;
      assign rd_space_flat[c*DCW +: DCW] = rd_space;

      assign elig[c] = (req_cnt != '0) &&
                       (req_head[AW] ? (wr_cnt >= BURST_C) : (rd_space >= BURST_C));
   end

   arb_pick #(.FIXED_PRIO(FIXED_PRIO)) u_pick (
      .elig (elig),
      .ptr  (ptr),
      .win  (win)
   );

   arb_burst_seq #(.AW(AW), .BURST(BURST)) u_seq (
      .clk          (clk),
      .rst          (rst),
      .win          (win),
      .win_write    (win[1] ? head_write[1] : head_write[0]),
      .win_addr     (win[1] ? head_addr[AW +: AW] : head_addr[0 +: AW]),
      .mc_req_ready (mc_req_ready),
      .mc_wr_take   (mc_wr_take),
      .mc_rd_valid  (mc_rd_valid),
      .gnt          (gnt),
      .launch       (launch),
      .ptr          (ptr),
      .mc_req_valid (mc_req_valid),
      .mc_write     (mc_write),
      .mc_addr      (mc_addr),
      .mc_wdata_oe  (mc_wdata_oe),
      .wr_beat      (wr_beat),
      .rd_beat      (rd_beat)
   );

   assign mc_wdata = gnt[1] ? wr_head[DW +: DW] : wr_head[0 +: DW];

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
   parameter int unsigned AW    = 24,
   parameter int unsigned DCW   = 5,
   parameter int unsigned BURST = 8
) (
   input logic           clk,
   input logic           rst,
   input logic           mc_req_valid,
   input logic           mc_req_ready,
   input logic           mc_write,
   input logic [AW-1:0]  mc_addr,
   input logic           mc_wdata_oe,
   input logic [1:0]     gnt,
   input logic [2*DCW-1:0] wr_cnt,
   input logic [2*DCW-1:0] rd_space
);

   localparam logic [DCW-1:0] BC = DCW'(BURST);

   a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt));

   a_r1_no_cmd_in_burst: assert property (@(posedge clk) disable iff (rst)
      mc_wdata_oe |-> !mc_req_valid);

   a_r1_cmd_has_owner: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid || mc_wdata_oe) |-> (gnt != 2'b00));

   a_r2_cmd_hold: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid && !mc_req_ready) |=>
         (mc_req_valid && $stable(mc_addr) && $stable(mc_write)));

   a_r4_write_stock_c0: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid && mc_write && gnt[0]) |-> (wr_cnt[0 +: DCW] >= BC));

   a_r4_write_stock_c1: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid && mc_write && gnt[1]) |-> (wr_cnt[DCW +: DCW] >= BC));

   a_r5_read_room_c0: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid && !mc_write && gnt[0]) |-> (rd_space[0 +: DCW] >= BC));

   a_r5_read_room_c1: assert property (@(posedge clk) disable iff (rst)
      (mc_req_valid && !mc_write && gnt[1]) |-> (rd_space[DCW +: DCW] >= BC));

endmodule

bind mem_req_arbiter arb_checker #(.AW(AW), .DCW(DCW), .BURST(BURST)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .mc_req_valid (mc_req_valid),
   .mc_req_ready (mc_req_ready),
   .mc_write     (mc_write),
   .mc_addr      (mc_addr),
   .mc_wdata_oe  (mc_wdata_oe),
   .gnt          (gnt),
   .wr_cnt       (wr_cnt_flat),
   .rd_space     (rd_space_flat)
);

// File: tb/sim_mem_req_arbiter.sv
`timescale 1ns/1ps
module sim_mem_req_arbiter;

   localparam int AW    = 24;
   localparam int DW    = 32;
   localparam int BURST = 8;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic [1:0]      cli_req_valid = '0, cli_req_write = '0;
   logic [2*AW-1:0] cli_req_addr = '0;
   logic [1:0]      cli_wr_valid = '0;
   logic [2*DW-1:0] cli_wr_data = '0;
   logic [1:0]      cli_rd_ready = '0;
   logic [1:0]      cli_req_ready, cli_wr_ready, cli_rd_valid;
   logic [2*DW-1:0] cli_rd_data;
   logic            mc_req_valid, mc_write, mc_wdata_oe;
   logic [AW-1:0]   mc_addr;
   logic [DW-1:0]   mc_wdata;
   logic            mc_req_ready = 1'b0, mc_wr_take = 1'b0, mc_rd_valid = 1'b0;
   logic [DW-1:0]   mc_rd_data = '0;

   int n_checks = 0, n_fail = 0;
   int wprod[2], wcons[2], rprod[2], rcons[2];
   bit done = 1'b0;

   always #4 clk = ~clk;

   mem_req_arbiter #(.AW(AW), .DW(DW), .BURST(BURST)) u0 (
      .clk(clk), .rst(rst),
      .cli_req_valid(cli_req_valid), .cli_req_ready(cli_req_ready),
      .cli_req_write(cli_req_write), .cli_req_addr(cli_req_addr),
      .cli_wr_valid(cli_wr_valid), .cli_wr_ready(cli_wr_ready), .cli_wr_data(cli_wr_data),
      .cli_rd_valid(cli_rd_valid), .cli_rd_ready(cli_rd_ready), .cli_rd_data(cli_rd_data),
      .mc_req_valid(mc_req_valid), .mc_req_ready(mc_req_ready),
      .mc_write(mc_write), .mc_addr(mc_addr), .mc_wdata(mc_wdata),
      .mc_wdata_oe(mc_wdata_oe), .mc_wr_take(mc_wr_take),
      .mc_rd_valid(mc_rd_valid), .mc_rd_data(mc_rd_data)
   );

   function automatic logic [DW-1:0] wword(int c, int n);
      return 32'hA000_0000 + 32'(c) * 32'h0001_0000 + 32'(n);
   endfunction

   function automatic logic [DW-1:0] rword(int c, int n);
      return 32'hB000_0000 + 32'(c) * 32'h0001_0000 + 32'(n);
   endfunction

   function automatic logic [AW-1:0] taddr(int c, int s);
      return AW'(c) << (AW - 1) | AW'(s);
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_req(input int c, input logic w, input logic [AW-1:0] a);
      cli_req_valid[c] = 1'b1;
      cli_req_write[c] = w;
      cli_req_addr[c*AW +: AW] = a;
      while (!cli_req_ready[c]) @(negedge clk);
      @(negedge clk);
      cli_req_valid[c] = 1'b0;
   endtask

   task automatic push_words(input int c, input int n);
      for (int i = 0; i < n; i++) begin
         cli_wr_valid[c] = 1'b1;
         cli_wr_data[c*DW +: DW] = wword(c, wprod[c]);
         while (!cli_wr_ready[c]) @(negedge clk);
         @(negedge clk);
         wprod[c]++;
      end
      cli_wr_valid[c] = 1'b0;
   endtask

   task automatic pop_rd(input int c, input int n);
      for (int i = 0; i < n; i++) begin
         check("R8 read port valid", 64'(cli_rd_valid[c]), 64'd1);
         check("R8 read word order", 64'(cli_rd_data[c*DW +: DW]), 64'(rword(c, rcons[c])));
         rcons[c]++;
         cli_rd_ready[c] = 1'b1;
         @(negedge clk);
         cli_rd_ready[c] = 1'b0;
      end
   endtask

   task automatic quiet(input int n, input string req);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mc_req_valid) begin
            check(req, 64'(mc_req_valid), 64'd0);
            return;
         end
      end
      check(req, 64'(mc_req_valid), 64'd0);
   endtask

   // Controller model: waits for a command, checks it, runs the burst.
   task automatic serve(input int dly, input logic [AW-1:0] exp_addr, input logic exp_w,
                        input string req);
      int c, guard;
      logic [AW-1:0] a0;
      guard = 0;
      while (!mc_req_valid && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      check({req, " command issued"}, 64'(mc_req_valid), 64'd1);
      check({req, " command address"}, 64'(mc_addr), 64'(exp_addr));
      check({req, " command direction"}, 64'(mc_write), 64'(exp_w));
      a0 = mc_addr;
      for (int d = 0; d < dly; d++) begin
         @(negedge clk);
         check("R2 command held", {63'd0, mc_req_valid}, 64'd1);
         check("R2 address stable", 64'(mc_addr), 64'(a0));
      end
      c = exp_addr[AW-1] ? 1 : 0;
      mc_req_ready = 1'b1;
      @(negedge clk);
      mc_req_ready = 1'b0;
      for (int k = 0; k < BURST; k++) begin
         if (k == 3) begin
            @(negedge clk);
            check("R1 no command during burst", 64'(mc_req_valid), 64'd0);
            if (exp_w) check("R7 enable held in gap", 64'(mc_wdata_oe), 64'd1);
         end
         check("R1 no command during burst", 64'(mc_req_valid), 64'd0);
         if (exp_w) begin
            mc_wr_take = 1'b1;
            check("R7 write enable", 64'(mc_wdata_oe), 64'd1);
            check("R7 write word order", 64'(mc_wdata), 64'(wword(c, wcons[c])));
            wcons[c]++;
         end else begin
            mc_rd_valid = 1'b1;
            mc_rd_data  = rword(c, rprod[c]);
            rprod[c]++;
         end
         @(negedge clk);
         mc_wr_take  = 1'b0;
         mc_rd_valid = 1'b0;
      end
      check("R7 enable low after burst", 64'(mc_wdata_oe), 64'd0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      check("R10 no command", 64'(mc_req_valid), 64'd0);
      check("R10 enable low", 64'(mc_wdata_oe), 64'd0);
      check("R10 read empty", 64'(cli_rd_valid), 64'd0);
      check("R10 command ready", 64'(cli_req_ready), 64'd3);
      check("R10 write ready", 64'(cli_wr_ready), 64'd3);

      // Write burst, client 0
      push_req(0, 1'b1, taddr(0, 1));
      push_words(0, BURST);
      serve(0, taddr(0, 1), 1'b1, "R7 basic write");

      // R4: write waits for a whole burst of data
      push_req(0, 1'b1, taddr(0, 2));
      push_words(0, 5);
      quiet(20, "R4 short write stock blocks");
      push_words(0, 3);
      serve(2, taddr(0, 2), 1'b1, "R4 write after stock filled");

      // R9: stray strobes while idle
      push_words(1, BURST);
      mc_rd_valid = 1'b1; mc_rd_data = 32'hDEAD_BEEF; mc_wr_take = 1'b1;
      repeat (3) @(negedge clk);
      mc_rd_valid = 1'b0; mc_wr_take = 1'b0;
      check("R9 stray read beats dropped", 64'(cli_rd_valid), 64'd0);
      push_req(1, 1'b1, taddr(1, 9));
      serve(0, taddr(1, 9), 1'b1, "R9 write words intact");

      // R8 and R5: reads into client 1
      push_req(1, 1'b0, taddr(1, 1));
      serve(1, taddr(1, 1), 1'b0, "R8 read one");
      check("R8 only granted client filled", 64'(cli_rd_valid), 64'd2);
      push_req(1, 1'b0, taddr(1, 2));
      serve(0, taddr(1, 2), 1'b0, "R8 read two");
      push_req(1, 1'b0, taddr(1, 3));
      quiet(20, "R5 full read FIFO blocks");
      pop_rd(1, BURST);
      serve(0, taddr(1, 3), 1'b0, "R5 read after room made");
      pop_rd(1, 2 * BURST);

      // R6: blocked client 0 does not stall client 1
      push_req(0, 1'b1, taddr(0, 3));
      push_req(1, 1'b0, taddr(1, 4));
      serve(0, taddr(1, 4), 1'b0, "R6 other client served");
      pop_rd(1, BURST);
      quiet(10, "R4 blocked write stays queued");

      // R11: command FIFO fills
      push_req(0, 1'b1, taddr(0, 4));
      push_req(0, 1'b1, taddr(0, 5));
      push_req(0, 1'b1, taddr(0, 6));
      check("R11 command port full", 64'(cli_req_ready[0]), 64'd0);

      // R3: both eligible while a command waits unacknowledged
      push_words(1, 2 * BURST);
      push_req(1, 1'b1, taddr(1, 5));
      push_req(1, 1'b1, taddr(1, 6));
      push_words(0, 2 * BURST);
      serve(3, taddr(1, 5), 1'b1, "R3 lone client 1");
      serve(0, taddr(0, 3), 1'b1, "R3 client 0 after client 1");
      serve(0, taddr(1, 6), 1'b1, "R3 client 1 after client 0");
      serve(0, taddr(0, 4), 1'b1, "R3 client 0 again");
      quiet(10, "R4 client 0 out of data");
      push_words(0, 2 * BURST);
      serve(0, taddr(0, 5), 1'b1, "R3 single eligible client");
      serve(0, taddr(0, 6), 1'b1, "R3 single eligible client");
      quiet(10, "R1 idle after all commands");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

endmodule